// File: doc/BRIEF.md
# DMA Handshake Buffer Loader

This block is a slave DMA channel that moves a programmed block of bytes between the shared 8-bit host data bus and the data region of an on-chip buffer memory. Software writes a start pointer, a byte count and a control word. The channel then holds an active-low request line low until the block is finished. An external DMA controller answers each request with an active-low acknowledge, and a byte moves when the acknowledge is low and the matching bus strobe falls.

The transfer can run in either direction. In the to-buffer direction, the write strobe stores the bus byte at the current pointer. In the from-buffer direction, the read strobe presents the byte at the current pointer on the read-data output. After each byte the pointer steps forward and wraps inside the data region, so register space is never reached. The remaining count steps down by one. When the count reaches zero, the request releases and a sticky completion flag sets. The flag stays set until software re-enables the channel.

All inputs are synchronous to `clk`. A strobe counts once, on the cycle where it is first seen low.

Top module: `dma_buf_loader`

## Requirements
- R1: After reset, `dreq_n` is 1, `xfer_left` is 0, `xfer_done` is 0, `mem_we` is 0 and `mem_addr` is 0x40.
- R2: `dreq_n` is low exactly while the enable bit is 1 and `xfer_left` is nonzero. It returns high in the cycle after the final byte is accepted.
- R3: In the to-buffer direction (control bit 1 = 0), a byte is accepted in the first cycle where `bus_wr_n` is low after being high, while `dack_n` is low and the request is active. In that cycle `mem_we` is 1, `mem_wdata` equals `bus_wdata` and `mem_addr` equals the current pointer.
- R4: In the from-buffer direction (control bit 1 = 1), a byte is accepted on a falling `bus_rd_n` under the same conditions. While `dack_n` and `bus_rd_n` are both low and the request is active, `bus_rdata_en` is 1 and `bus_rdata` equals `mem_rdata`. The strobe of the other direction has no effect.
- R5: Each accepted byte advances the pointer (`mem_addr`) by one and lowers `xfer_left` by one, both visible from the next cycle.
- R6: The pointer wraps from 0xFF to 0x40. A start pointer written below 0x40 loads as 0x40.
- R7: `xfer_done` sets in the cycle `xfer_left` reaches zero through a byte. It stays set through pointer, count and disabling control writes. A control write with bit 0 = 1 clears it.
- R8: An acknowledge or strobe while the request is inactive changes neither the pointer nor `xfer_left`, and it raises no `mem_we`. A strobe held low for several cycles moves only one byte.
- R9: Configuration uses `cfg_sel`. 0 selects control (bit 0 enable, bit 1 direction), 1 loads the start pointer, 2 loads the byte count, and 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| dreq_n | output | 1 | DMA request, active low |
| dack_n | input | 1 | DMA acknowledge, active low |
| bus_wr_n | input | 1 | Shared bus write strobe, active low |
| bus_rd_n | input | 1 | Shared bus read strobe, active low |
| bus_wdata | input | 8 | Bus data toward the buffer |
| bus_rdata | output | 8 | Bus data from the buffer |
| bus_rdata_en | output | 1 | Read data is being driven for a DMA read |
| mem_addr | output | 8 | Buffer address (current pointer) |
| mem_we | output | 1 | Buffer write enable |
| mem_wdata | output | 8 | Buffer write data |
| mem_rdata | input | 8 | Buffer read data at `mem_addr` |
| xfer_left | output | 8 | Bytes remaining in the block |
| xfer_done | output | 1 | Sticky block-complete flag |

## Verification
The assertions assume that configuration writes do not coincide with the final byte of a block. They also assume that the acknowledge and strobes are synchronous levels, each sampled once per clock.

The bench drives every handshake at the falling clock edge and returns each strobe high for at least one full cycle between bytes. It always issues register writes while no byte is in flight. Random block starts and lengths are drawn inside the data region so that wrap-around occurs, and each block is written and then read back.

// File: rtl/dma_ldr_pkg.sv
package dma_ldr_pkg;

    typedef enum logic {
        DIR_TO_BUF   = 1'b0,
        DIR_FROM_BUF = 1'b1
    } dma_dir_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_PTR  = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;

    typedef struct packed {
        logic     en;
        dma_dir_e dir;
    } ctrl_t;

endpackage

// File: rtl/dma_ldr_edge.sv
module dma_ldr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall
);
    logic act_d, act_q;

    always_comb begin
        act_d = ~strobe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act_d;
    end

    assign fall = ~strobe_n & ~act_q;

    AST_FALL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R8
endmodule

// File: rtl/dma_ldr_ptr.sv
module dma_ldr_ptr #(
    parameter int AW = 8,
    parameter int LO = 64,
    parameter int HI = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LO_V = AW'(LO);
    localparam logic [AW-1:0] HI_V = AW'(HI);
    localparam logic [AW:0]   HI_W = (AW+1)'(HI);

    logic [AW-1:0] ptr_d, ptr_q;
    logic          out_of_region;

    always_comb begin
        out_of_region = (load_val < LO_V) || ({1'b0, load_val} > HI_W);
        ptr_d = ptr_q;
        if (load) begin
            ptr_d = out_of_region ? LO_V : load_val;
        end else if (step) begin
            ptr_d = (ptr_q == HI_V) ? LO_V : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= LO_V;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    AST_PTR_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr >= LO_V) && ({1'b0, ptr} <= HI_W)); // R6
    AST_PTR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (ptr != $past(ptr))); // R5
endmodule

// File: rtl/dma_ldr_cnt.sv
module dma_ldr_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          rearm,
    input  logic          step,
    output logic [CW-1:0] left,
    output logic          done
);
    typedef struct packed {
        logic [CW-1:0] left;
        logic          done;
    } cnt_state_t;

    localparam logic [CW-1:0] ONE = CW'(1);

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.left = load_val;
        end else if (step && (st_q.left != '0)) begin
            st_d.left = st_q.left - 1'b1;
        end
        if (rearm) begin
            st_d.done = 1'b0;
        end else if (step && !load && (st_q.left == ONE)) begin
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left = st_q.left;
    assign done = st_q.done;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (left == $past(left) - 1'b1)); // R5
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rearm) |=> done); // R7
endmodule

// File: rtl/dma_buf_loader.sv
module dma_buf_loader
    import dma_ldr_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int CNT_W     = 8,
    parameter int REGION_LO = 64,
    parameter int REGION_HI = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              dreq_n,
    input  logic              dack_n,
    input  logic              bus_wr_n,
    input  logic              bus_rd_n,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rdata_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  xfer_left,
    output logic              xfer_done
);
    localparam int NUM_STROBES = 2;

    ctrl_t ctrl_d, ctrl_q;

    logic [NUM_STROBES-1:0] strobe_n;
    logic [NUM_STROBES-1:0] fall;
    logic                   ld_ctrl, ld_ptr, ld_cnt, rearm;
    logic                   active, dir_fall, byte_ok;
    logic [ADDR_W-1:0]      ptr;
    logic [CNT_W-1:0]       left;
    logic                   done;

    assign strobe_n = {bus_rd_n, bus_wr_n};

    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_edge
        dma_ldr_edge u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_n (strobe_n[g]),
            .fall     (fall[g])
        );
    end

    always_comb begin
        ld_ctrl = cfg_we && (cfg_sel == SEL_CTRL);
        ld_ptr  = cfg_we && (cfg_sel == SEL_PTR);
        ld_cnt  = cfg_we && (cfg_sel == SEL_CNT);
        rearm   = ld_ctrl && cfg_wdata[0];

        ctrl_d = ctrl_q;
        if (ld_ctrl) begin
            ctrl_d.en  = cfg_wdata[0];
            ctrl_d.dir = dma_dir_e'(cfg_wdata[1]);
        end

        active   = ctrl_q.en && (left != '0);
        dir_fall = (ctrl_q.dir == DIR_FROM_BUF) ? fall[1] : fall[0];
        byte_ok  = active && !dack_n && dir_fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '{en: 1'b0, dir: DIR_TO_BUF};
        else        ctrl_q <= ctrl_d;
    end

    dma_ldr_ptr #(
        .AW (ADDR_W),
        .LO (REGION_LO),
        .HI (REGION_HI)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_ptr),
        .load_val (ADDR_W'(cfg_wdata)),
        .step     (byte_ok),
        .ptr      (ptr)
    );

    dma_ldr_cnt #(
        .CW (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_cnt),
        .load_val (CNT_W'(cfg_wdata)),
        .rearm    (rearm),
        .step     (byte_ok),
        .left     (left),
        .done     (done)
    );

    assign dreq_n       = ~active;
    assign mem_addr     = ptr;
    assign mem_we       = byte_ok && (ctrl_q.dir == DIR_TO_BUF);
    assign mem_wdata    = bus_wdata;
    assign bus_rdata    = mem_rdata;
    assign bus_rdata_en = active && (ctrl_q.dir == DIR_FROM_BUF) && !dack_n && !bus_rd_n;
    assign xfer_left    = left;
    assign xfer_done    = done;

    AST_IDLE_ACK_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq_n && !cfg_we) |=> ($stable(mem_addr) && $stable(xfer_left))); // R8
    AST_WE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (!dreq_n && !dack_n && !bus_wr_n)); // R3
    AST_LAST_BYTE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ok && (xfer_left == CNT_W'(1)) && !cfg_we) |=> (dreq_n && xfer_done)); // R2
    AST_RD_EN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_en |-> (!mem_we && !bus_rd_n)); // R4
endmodule

// File: tb/test_dma_buf_loader.sv
module test_dma_buf_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       dreq_n;
    logic       dack_n = 1'b1;
    logic       bus_wr_n = 1'b1;
    logic       bus_rd_n = 1'b1;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       bus_rdata_en;
    logic [7:0] mem_addr;
    logic       mem_we;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;
    logic [7:0] xfer_left;
    logic       xfer_done;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] mem_model [0:255];
    logic [7:0] exp_mem   [0:255];

    always #10 clk = ~clk;

    dma_buf_loader i_dma_buf_loader (
        .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .dreq_n, .dack_n,
        .bus_wr_n, .bus_rd_n, .bus_wdata, .bus_rdata, .bus_rdata_en,
        .mem_addr, .mem_we, .mem_wdata, .mem_rdata, .xfer_left, .xfer_done
    );

    assign mem_rdata = mem_model[mem_addr];
    always @(posedge clk) if (mem_we) mem_model[mem_addr] <= mem_wdata;

    function automatic int next_ptr(input int p);
        return (p == 255) ? 64 : p + 1;
    endfunction

    function automatic int clamp_ptr(input int p);
        return (p < 64) ? 64 : p;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
    endtask

    task automatic xfer_byte(input bit rd, input logic [7:0] wd, input int p_exp);
        @(negedge clk);
        dack_n = 1'b0;
        if (rd) bus_rd_n = 1'b0;
        else begin bus_wr_n = 1'b0; bus_wdata = wd; end
        #5;
        check("R3/R4 byte address", mem_addr, p_exp);
        if (rd) begin
            check("R4 rdata_en", bus_rdata_en, 1);
            check("R4 read data", bus_rdata, exp_mem[p_exp]);
        end else begin
            check("R3 mem_we", mem_we, 1);
            check("R3 mem_wdata", mem_wdata, wd);
            exp_mem[p_exp] = wd;
        end
        @(negedge clk);
        dack_n = 1'b1; bus_rd_n = 1'b1; bus_wr_n = 1'b1;
        #1;
    endtask

    task automatic run_xfer(input int start, input int cnt, input bit rd);
        int p = clamp_ptr(start);
        cfg_write(2'd1, 8'(start));
        cfg_write(2'd2, 8'(cnt));
        cfg_write(2'd0, {6'd0, rd, 1'b1});
        check("R2 request after arm", dreq_n, (cnt == 0) ? 1 : 0);
        check("R7 done cleared by rearm", xfer_done, 0);
        for (int i = 0; i < cnt; i++) begin
            xfer_byte(rd, 8'($urandom), p);
            p = next_ptr(p);
            check("R5/R6 pointer step", mem_addr, p);
            check("R5 count step", xfer_left, cnt - 1 - i);
        end
        check("R2 request released", dreq_n, 1);
        check("R7 done set", xfer_done, (cnt == 0) ? 0 : 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int seed_junk;
        int a, l;
        int p;
        logic [7:0] hd;
        seed_junk = $urandom(32'd4711);
        for (int i = 0; i < 256; i++) begin
            mem_model[i] = 8'h00;
            exp_mem[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 dreq_n", dreq_n, 1);
        check("R1 xfer_left", xfer_left, 0);
        check("R1 xfer_done", xfer_done, 0);
        check("R1 mem_we", mem_we, 0);
        check("R1 mem_addr", mem_addr, 8'h40);

        // R6 wrap across 0xFF, written then read back (R3, R4)
        run_xfer(8'hFC, 8, 1'b0);
        run_xfer(8'hFC, 8, 1'b1);

        // R8 acknowledge and strobe while idle
        a = mem_addr; l = xfer_left;
        @(negedge clk);
        dack_n = 1'b0; bus_wr_n = 1'b0; bus_wdata = 8'hAA;
        #5 check("R8 idle mem_we", mem_we, 0);
        @(negedge clk);
        dack_n = 1'b1; bus_wr_n = 1'b1;
        #1;
        check("R8 idle pointer", mem_addr, a);
        check("R8 idle count", xfer_left, l);

        // R9 select 3 ignored
        cfg_write(2'd3, 8'h55);
        check("R9 sel3 pointer", mem_addr, a);
        check("R9 sel3 count", xfer_left, l);

        // R6 clamp, R7 done survives non-arming writes
        cfg_write(2'd1, 8'h10);
        check("R6 clamp start", mem_addr, 8'h40);
        check("R7 done after pointer write", xfer_done, 1);
        cfg_write(2'd2, 8'd5);
        cfg_write(2'd0, 8'h00);
        check("R2 disabled no request", dreq_n, 1);
        check("R7 done after disable", xfer_done, 1);
        cfg_write(2'd0, 8'h01);
        check("R7 rearm clears done", xfer_done, 0);
        check("R2 enabled request", dreq_n, 0);

        // R4 read strobe ignored in to-buffer direction
        @(negedge clk);
        dack_n = 1'b0; bus_rd_n = 1'b0;
        #5;
        check("R4 wrong strobe mem_we", mem_we, 0);
        check("R4 wrong strobe rdata_en", bus_rdata_en, 0);
        @(negedge clk);
        dack_n = 1'b1; bus_rd_n = 1'b1;
        #1;
        check("R4 wrong strobe count", xfer_left, 5);
        check("R4 wrong strobe pointer", mem_addr, 8'h40);

        // R8 held strobe moves one byte
        hd = 8'h3C;
        @(negedge clk);
        dack_n = 1'b0; bus_wr_n = 1'b0; bus_wdata = hd;
        repeat (3) @(negedge clk);
        dack_n = 1'b1; bus_wr_n = 1'b1;
        #1;
        exp_mem[8'h40] = hd;
        check("R8 held strobe count", xfer_left, 4);
        check("R8 held strobe pointer", mem_addr, 8'h41);
        p = 8'h41;
        for (int i = 0; i < 4; i++) begin
            xfer_byte(1'b0, 8'($urandom), p);
            p = next_ptr(p);
        end
        check("R2 release after block", dreq_n, 1);
        check("R7 done after block", xfer_done, 1);
        run_xfer(8'h40, 5, 1'b1);

        // random blocks, write then read back
        for (int k = 0; k < 8; k++) begin
            int st, ct;
            st = 64 + int'($urandom % 192);
            ct = 1 + int'($urandom % 20);
            run_xfer(st, ct, 1'b0);
            run_xfer(st, ct, 1'b1);
        end

        report();
        $finish;
    end
endmodule